// File: doc/BRIEF.md
# Board System Control Port

This block is a byte-wide I/O port register bank for a PC-style board. A host reaches it over a plain bus: one read strobe, one write strobe, a 16-bit port number and an 8-bit data byte. Writes to a handful of ports drive board-level levels: a reset request, a little-endian mode select, a disk activity lamp, a 4-bit system control field and an I/O map mode select. Two other ports produce single-cycle toggle pulses that an attached non-volatile memory uses to flip its write locks. A further set of ports return fixed identification and equipment bytes.

Each strobe is sampled on a rising clock edge. The access is captured by a small state machine with three states: `ST_IDLE` (no access in the previous cycle), `ST_RD_RESP` (read data is being presented) and `ST_WR_RESP` (write side effects such as lock pulses are being presented). Every state moves to `ST_WR_RESP` on a write strobe, to `ST_RD_RESP` on a read strobe without a write, and to `ST_IDLE` otherwise. The stored levels change at the same edge that captures the write. A port that is not decoded for the requested direction reads as 0xFF and raises an error flag for one cycle.

Top module: `brd_ctl_port`

## Requirements
- R1: Reset (rst_n low) clears every output to zero: rdata, rdata_vld, acc_err, rst_req, little_endian, disk_led, both lock pulses, sys_ctl and io_map_sel.
- R2: A write to port 0x0092 sets rst_req to data bit 0 and little_endian to data bit 1; a read of 0x0092 returns 0x00 whatever was written.
- R3: Reads return fixed bytes: 0x0800 gives 0xEF, 0x0802 gives 0xAD, 0x0803 gives 0xE0, 0x080C gives 0x3C, 0x0810 gives 0x39, 0x0818 gives 0x00, 0x0823 gives 0x03. Writes to 0x0800, 0x0802 and 0x0803 change no output and raise no error.
- R4: A write to port 0x0808 sets disk_led from data bit 0 and leaves every other stored level unchanged.
- R5: A write to 0x0810 makes nv_lock1_tgl high for exactly the one cycle after the write strobe; a write to 0x0812 does the same on nv_lock2_tgl; the data byte has no effect on either.
- R6: A write to 0x081C stores data bits 3:0 on sys_ctl; a read of 0x081C returns that value with bits 7:4 zero; no other write changes sys_ctl.
- R7: A write to 0x0850 stores data bit 0 on io_map_sel; a read of 0x0850 returns it in bit 0 with the other bits zero.
- R8: A write to 0x0814 is accepted with no effect and no error; a read of 0x0814 returns 0xFF with no error.
- R9: A read of any port other than 0x0092, 0x0800, 0x0802, 0x0803, 0x080C, 0x0810, 0x0814, 0x0818, 0x081C, 0x0823, 0x0850 returns 0xFF with acc_err high in the response cycle; a write to any port other than 0x0092, 0x0800, 0x0802, 0x0803, 0x0808, 0x0810, 0x0812, 0x0814, 0x081C, 0x0850 changes no output level and raises acc_err for that one cycle.
- R10: rdata_vld is high exactly in the cycle after a read strobe, and rdata is 0x00 in every cycle where rdata_vld is low.
- R11: When read and write strobes are high together, the access is a write only: its side effects occur and rdata_vld stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, sampled at the clock edge |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| addr | input | 16 | Port number of the access |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, valid while rdata_vld is high, else zero |
| rdata_vld | output | 1 | High in the cycle after a read strobe |
| acc_err | output | 1 | One-cycle flag for an access to an undecoded port |
| rst_req | output | 1 | Reset request level |
| little_endian | output | 1 | Little-endian mode level |
| disk_led | output | 1 | Disk activity lamp level |
| nv_lock1_tgl | output | 1 | One-cycle toggle pulse for memory lock 1 |
| nv_lock2_tgl | output | 1 | One-cycle toggle pulse for memory lock 2 |
| sys_ctl | output | 4 | Stored system control field |
| io_map_sel | output | 1 | Stored I/O map mode bit |

## Verification
The bound checker watches, on every cycle, the response timing of reads, the zero value of rdata outside a response, the 0xFF value of an erroring read, the source of each lock pulse, the reset-request and system-control updates, and the write-wins rule for simultaneous strobes. The fixed identification bytes, the ignored writes to read-only ports, the per-direction decode lists and the disk lamp and map-mode round trips rest on the bench's scenarios, which compare every output after each access against a model of the port list.

// File: rtl/brd_ctl_pkg.sv
package brd_ctl_pkg;

    // Port numbers whose decoding drives behaviour
    localparam logic [15:0] PA_SPECIAL = 16'h0092;
    localparam logic [15:0] PA_CPUCFG  = 16'h0800;
    localparam logic [15:0] PA_FEAT    = 16'h0802;
    localparam logic [15:0] PA_STAT    = 16'h0803;
    localparam logic [15:0] PA_LED     = 16'h0808;
    localparam logic [15:0] PA_EQUIP   = 16'h080C;
    localparam logic [15:0] PA_LOCK1   = 16'h0810;
    localparam logic [15:0] PA_LOCK2   = 16'h0812;
    localparam logic [15:0] PA_L2INV   = 16'h0814;
    localparam logic [15:0] PA_KEY     = 16'h0818;
    localparam logic [15:0] PA_SYSCTL  = 16'h081C;
    localparam logic [15:0] PA_L2STAT  = 16'h0823;
    localparam logic [15:0] PA_MAP     = 16'h0850;

    // Fixed read-back bytes
    localparam logic [7:0] RV_CPUCFG = 8'hEF;
    localparam logic [7:0] RV_FEAT   = 8'hAD;
    localparam logic [7:0] RV_STAT   = 8'hE0;
    localparam logic [7:0] RV_EQUIP  = 8'h3C;
    localparam logic [7:0] RV_XFEAT  = 8'h39;
    localparam logic [7:0] RV_KEY    = 8'h00;
    localparam logic [7:0] RV_L2STAT = 8'h03;
    localparam logic [7:0] RV_MISS   = 8'hFF;

    typedef enum logic [3:0] {
        PID_NONE,
        PID_SPECIAL,
        PID_CPUCFG,
        PID_FEAT,
        PID_STAT,
        PID_LED,
        PID_EQUIP,
        PID_LOCK1,
        PID_LOCK2,
        PID_L2INV,
        PID_KEY,
        PID_SYSCTL,
        PID_L2STAT,
        PID_MAP
    } port_id_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_RESP,
        ST_WR_RESP
    } acc_state_e;

endpackage

// File: rtl/brd_ctl_decode.sv
module brd_ctl_decode
    import brd_ctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output port_id_e          pid,
    output logic              rd_ok,
    output logic              wr_ok
);

    // Port number to identifier
    always_comb begin
        case (addr)
            ADDR_W'(PA_SPECIAL): pid = PID_SPECIAL;
            ADDR_W'(PA_CPUCFG):  pid = PID_CPUCFG;
            ADDR_W'(PA_FEAT):    pid = PID_FEAT;
            ADDR_W'(PA_STAT):    pid = PID_STAT;
            ADDR_W'(PA_LED):     pid = PID_LED;
            ADDR_W'(PA_EQUIP):   pid = PID_EQUIP;
            ADDR_W'(PA_LOCK1):   pid = PID_LOCK1;
            ADDR_W'(PA_LOCK2):   pid = PID_LOCK2;
            ADDR_W'(PA_L2INV):   pid = PID_L2INV;
            ADDR_W'(PA_KEY):     pid = PID_KEY;
            ADDR_W'(PA_SYSCTL):  pid = PID_SYSCTL;
            ADDR_W'(PA_L2STAT):  pid = PID_L2STAT;
            ADDR_W'(PA_MAP):     pid = PID_MAP;
            default:             pid = PID_NONE;
        endcase
    end

    // Direction-specific decode sets
    always_comb begin
        unique case (pid)
            PID_SPECIAL, PID_CPUCFG, PID_FEAT, PID_STAT, PID_LOCK1,
            PID_L2INV, PID_SYSCTL, PID_MAP: begin
                rd_ok = 1'b1;
                wr_ok = 1'b1;
            end
            PID_EQUIP, PID_KEY, PID_L2STAT: begin
                rd_ok = 1'b1;
                wr_ok = 1'b0;
            end
            PID_LED, PID_LOCK2: begin
                rd_ok = 1'b0;
                wr_ok = 1'b1;
            end
            default: begin
                rd_ok = 1'b0;
                wr_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs
    import brd_ctl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CTL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  port_id_e          pid,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val,
    output logic              rst_req,
    output logic              little_endian,
    output logic              disk_led,
    output logic [CTL_W-1:0]  sys_ctl,
    output logic              io_map_sel
);

    logic unused_hi_bits;
    assign unused_hi_bits = ^wdata[DATA_W-1:CTL_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req       <= 1'b0;
            little_endian <= 1'b0;
            disk_led      <= 1'b0;
            sys_ctl       <= '0;
            io_map_sel    <= 1'b0;
        end else if (wr_fire) begin
            case (pid)
                PID_SPECIAL: begin
                    rst_req       <= wdata[0];
                    little_endian <= wdata[1];
                end
                PID_LED:    disk_led   <= wdata[0];
                PID_SYSCTL: sys_ctl    <= wdata[CTL_W-1:0];
                PID_MAP:    io_map_sel <= wdata[0];
                default: ;
            endcase
        end
    end

    // Read-back multiplexer
    always_comb begin
        case (pid)
            PID_SPECIAL: rd_val = '0;
            PID_CPUCFG:  rd_val = DATA_W'(RV_CPUCFG);
            PID_FEAT:    rd_val = DATA_W'(RV_FEAT);
            PID_STAT:    rd_val = DATA_W'(RV_STAT);
            PID_EQUIP:   rd_val = DATA_W'(RV_EQUIP);
            PID_LOCK1:   rd_val = DATA_W'(RV_XFEAT);
            PID_KEY:     rd_val = DATA_W'(RV_KEY);
            PID_SYSCTL:  rd_val = DATA_W'(sys_ctl);
            PID_L2STAT:  rd_val = DATA_W'(RV_L2STAT);
            PID_MAP:     rd_val = DATA_W'(io_map_sel);
            default:     rd_val = DATA_W'(RV_MISS);
        endcase
    end

endmodule

// File: rtl/brd_ctl_fsm.sv
module brd_ctl_fsm
    import brd_ctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  port_id_e          pid,
    input  logic              rd_ok,
    input  logic              wr_ok,
    input  logic [DATA_W-1:0] rd_val,
    output logic              wr_fire,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld,
    output logic              acc_err,
    output logic              nv_lock1_tgl,
    output logic              nv_lock2_tgl
);

    acc_state_e        state_q, state_d;
    port_id_e          pid_q;
    logic              miss_q;
    logic [DATA_W-1:0] rd_q;

    assign wr_fire = wr_en && wr_ok;

    // Next-state selection
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_RD_RESP, ST_WR_RESP: begin
                if (wr_en)      state_d = ST_WR_RESP;
                else if (rd_en) state_d = ST_RD_RESP;
                else            state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and access capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pid_q   <= PID_NONE;
            miss_q  <= 1'b0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            pid_q   <= pid;
            if (wr_en) begin
                miss_q <= !wr_ok;
            end else if (rd_en) begin
                miss_q <= !rd_ok;
                rd_q   <= rd_val;
            end else begin
                miss_q <= 1'b0;
            end
        end
    end

    // Outputs per state
    always_comb begin
        rdata        = '0;
        rdata_vld    = 1'b0;
        acc_err      = 1'b0;
        nv_lock1_tgl = 1'b0;
        nv_lock2_tgl = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD_RESP: begin
                rdata     = rd_q;
                rdata_vld = 1'b1;
                acc_err   = miss_q;
            end
            ST_WR_RESP: begin
                acc_err      = miss_q;
                nv_lock1_tgl = (pid_q == PID_LOCK1);
                nv_lock2_tgl = (pid_q == PID_LOCK2);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/brd_ctl_port.sv
module brd_ctl_port
    import brd_ctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CTL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld,
    output logic              acc_err,
    output logic              rst_req,
    output logic              little_endian,
    output logic              disk_led,
    output logic              nv_lock1_tgl,
    output logic              nv_lock2_tgl,
    output logic [CTL_W-1:0]  sys_ctl,
    output logic              io_map_sel
);

    port_id_e          pid;
    logic              rd_ok, wr_ok, wr_fire;
    logic [DATA_W-1:0] rd_val;

    brd_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (addr),
        .pid   (pid),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok)
    );

    brd_ctl_regs #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_fire       (wr_fire),
        .pid           (pid),
        .wdata         (wdata),
        .rd_val        (rd_val),
        .rst_req       (rst_req),
        .little_endian (little_endian),
        .disk_led      (disk_led),
        .sys_ctl       (sys_ctl),
        .io_map_sel    (io_map_sel)
    );

    brd_ctl_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .wr_en        (wr_en),
        .pid          (pid),
        .rd_ok        (rd_ok),
        .wr_ok        (wr_ok),
        .rd_val       (rd_val),
        .wr_fire      (wr_fire),
        .rdata        (rdata),
        .rdata_vld    (rdata_vld),
        .acc_err      (acc_err),
        .nv_lock1_tgl (nv_lock1_tgl),
        .nv_lock2_tgl (nv_lock2_tgl)
    );

endmodule

// File: rtl/brd_ctl_port_chk.sv
module brd_ctl_port_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CTL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CTL_W-1:0]  wdata_lo,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_vld,
    input logic              acc_err,
    input logic              rst_req,
    input logic              nv_lock1_tgl,
    input logic              nv_lock2_tgl,
    input logic [CTL_W-1:0]  sys_ctl
);

    // R10: response one cycle after a lone read strobe
    a_r10_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> rdata_vld);

    // R10: read bus idles at zero
    a_r10_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_vld |-> (rdata == '0));

    // R9: an erroring read shows all ones
    a_r9_miss_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err && rdata_vld) |-> (rdata == {DATA_W{1'b1}}));

    // R2: reset request follows data bit 0
    a_r2_rst_req: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(16'h0092)) |=> (rst_req == $past(wdata_lo[0])));

    // R5: lock pulses come only from their own port writes
    a_r5_lock1_src: assert property (@(posedge clk) disable iff (!rst_n)
        nv_lock1_tgl |-> ($past(wr_en) && $past(addr) == ADDR_W'(16'h0810)));
    a_r5_lock2_src: assert property (@(posedge clk) disable iff (!rst_n)
        nv_lock2_tgl |-> ($past(wr_en) && $past(addr) == ADDR_W'(16'h0812)));
    a_r5_lock1_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(16'h0810)) |=> nv_lock1_tgl);

    // R6: system control field moves only on its port write
    a_r6_sysctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(16'h081C)) |=> $stable(sys_ctl));
    a_r6_sysctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(16'h081C)) |=> (sys_ctl == $past(wdata_lo)));

    // R11: write wins when both strobes rise together
    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> !rdata_vld);

endmodule

bind brd_ctl_port brd_ctl_port_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_W(CTL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata_lo     (wdata[CTL_W-1:0]),
    .rdata        (rdata),
    .rdata_vld    (rdata_vld),
    .acc_err      (acc_err),
    .rst_req      (rst_req),
    .nv_lock1_tgl (nv_lock1_tgl),
    .nv_lock2_tgl (nv_lock2_tgl),
    .sys_ctl      (sys_ctl)
);

// File: tb/brd_ctl_port_bench.sv
module brd_ctl_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_vld, acc_err, rst_req, little_endian, disk_led;
    logic        nv_lock1_tgl, nv_lock2_tgl, io_map_sel;
    logic [3:0]  sys_ctl;

    always #2 clk = ~clk;

    brd_ctl_port u_brd_ctl_port (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld), .acc_err(acc_err),
        .rst_req(rst_req), .little_endian(little_endian), .disk_led(disk_led),
        .nv_lock1_tgl(nv_lock1_tgl), .nv_lock2_tgl(nv_lock2_tgl),
        .sys_ctl(sys_ctl), .io_map_sel(io_map_sel)
    );

    // Expected snapshot of all outputs: vld, rdata, err, l1, l2, rst, le, led, sys, map
    typedef struct packed {
        logic       vld;
        logic [7:0] rd;
        logic       err;
        logic       l1;
        logic       l2;
        logic       rst;
        logic       le;
        logic       led;
        logic [3:0] sys;
        logic       map;
    } snap_t;

    snap_t  exp_q[$];
    string  tag_q[$];
    int     due_q[$];
    int     cyc = 0;
    int     n_run = 0;
    int     n_fail = 0;
    bit     done = 0;

    logic       m_rst = 0, m_le = 0, m_led = 0, m_map = 0;
    logic [3:0] m_sys = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit rd_known(input logic [15:0] a);
        case (a)
            16'h0092, 16'h0800, 16'h0802, 16'h0803, 16'h080C, 16'h0810,
            16'h0814, 16'h0818, 16'h081C, 16'h0823, 16'h0850: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit wr_known(input logic [15:0] a);
        case (a)
            16'h0092, 16'h0800, 16'h0802, 16'h0803, 16'h0808, 16'h0810,
            16'h0812, 16'h0814, 16'h081C, 16'h0850: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] rd_model(input logic [15:0] a);
        case (a)
            16'h0092: return 8'h00;
            16'h0800: return 8'hEF;
            16'h0802: return 8'hAD;
            16'h0803: return 8'hE0;
            16'h080C: return 8'h3C;
            16'h0810: return 8'h39;
            16'h0818: return 8'h00;
            16'h081C: return {4'h0, m_sys};
            16'h0823: return 8'h03;
            16'h0850: return {7'h0, m_map};
            default:  return 8'hFF;
        endcase
    endfunction

    function automatic snap_t levels();
        snap_t s;
        s = '0;
        s.rst = m_rst; s.le = m_le; s.led = m_led; s.sys = m_sys; s.map = m_map;
        return s;
    endfunction

    // Driver: one access per cycle, expected outputs pushed to the scoreboard
    task automatic access(input bit rd, input bit wr, input logic [15:0] a,
                          input logic [7:0] d, input string tag);
        snap_t s;
        @(negedge clk);
        rd_en = rd; wr_en = wr; addr = a; wdata = d;
        if (wr) begin
            if (wr_known(a)) begin
                case (a)
                    16'h0092: begin m_rst = d[0]; m_le = d[1]; end
                    16'h0808: m_led = d[0];
                    16'h081C: m_sys = d[3:0];
                    16'h0850: m_map = d[0];
                    default: ;
                endcase
            end
            s = levels();
            s.err = !wr_known(a);
            s.l1 = (a == 16'h0810);
            s.l2 = (a == 16'h0812);
        end else if (rd) begin
            s = levels();
            s.vld = 1'b1;
            s.rd = rd_model(a);
            s.err = !rd_known(a);
        end else begin
            s = levels();
        end
        exp_q.push_back(s);
        tag_q.push_back(tag);
        due_q.push_back(cyc + 1);
    endtask

    task automatic idle(input string tag);
        access(1'b0, 1'b0, 16'h0000, 8'h00, tag);
    endtask

    function automatic snap_t observed();
        snap_t s;
        s.vld = rdata_vld; s.rd = rdata; s.err = acc_err;
        s.l1 = nv_lock1_tgl; s.l2 = nv_lock2_tgl; s.rst = rst_req;
        s.le = little_endian; s.led = disk_led; s.sys = sys_ctl; s.map = io_map_sel;
        return s;
    endfunction

    // Monitor: compare outputs in the response cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0 && due_q[0] == cyc) begin
            snap_t e, g;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            void'(due_q.pop_front());
            g = observed();
            n_run++;
            if (g !== e) begin
                n_fail++;
                $display("FAIL %s: got vld=%0b rd=%02h err=%0b l1=%0b l2=%0b rst=%0b le=%0b led=%0b sys=%h map=%0b, expected vld=%0b rd=%02h err=%0b l1=%0b l2=%0b rst=%0b le=%0b led=%0b sys=%h map=%0b",
                         t, g.vld, g.rd, g.err, g.l1, g.l2, g.rst, g.le, g.led, g.sys, g.map,
                         e.vld, e.rd, e.err, e.l1, e.l2, e.rst, e.le, e.led, e.sys, e.map);
            end
        end
    end

    task automatic check_reset(input string tag);
        snap_t g;
        n_run++;
        g = observed();
        if (g !== '0) begin
            n_fail++;
            $display("FAIL %s: got outputs %h after reset, expected %h", tag, g, snap_t'(0));
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset("R1 reset held");
        rst_n = 1'b1;
        idle("R1 after release");

        // R2 special port
        access(0, 1, 16'h0092, 8'h03, "R2 write 0x03");
        access(1, 0, 16'h0092, 8'h00, "R2 read returns 0");
        access(0, 1, 16'h0092, 8'h02, "R2 write 0x02");
        access(0, 1, 16'h0092, 8'h01, "R2 write 0x01");

        // R3 identification bytes and ignored writes
        access(1, 0, 16'h0800, 8'h00, "R3 read 0x0800");
        access(1, 0, 16'h0802, 8'h00, "R3 read 0x0802");
        access(1, 0, 16'h0803, 8'h00, "R3 read 0x0803");
        access(1, 0, 16'h080C, 8'h00, "R3 read 0x080C");
        access(1, 0, 16'h0810, 8'h00, "R3 read 0x0810");
        access(1, 0, 16'h0818, 8'h00, "R3 read 0x0818");
        access(1, 0, 16'h0823, 8'h00, "R3 read 0x0823");
        access(0, 1, 16'h0800, 8'h55, "R3 write 0x0800 ignored");
        access(0, 1, 16'h0802, 8'hFF, "R3 write 0x0802 ignored");
        access(0, 1, 16'h0803, 8'h00, "R3 write 0x0803 ignored");
        access(1, 0, 16'h0800, 8'h00, "R3 reread 0x0800");

        // R4 disk lamp
        access(0, 1, 16'h0808, 8'h01, "R4 lamp on");
        access(0, 1, 16'h0808, 8'hFE, "R4 lamp off by bit 0");

        // R5 lock pulses
        access(0, 1, 16'h0810, 8'h00, "R5 lock1 data 0");
        idle("R5 lock1 pulse ends");
        access(0, 1, 16'h0812, 8'hFF, "R5 lock2 data FF");
        access(0, 1, 16'h0810, 8'hA5, "R5 lock1 back to back");
        idle("R5 pulses end");

        // R6 system control
        access(0, 1, 16'h081C, 8'hA7, "R6 write sysctl");
        access(1, 0, 16'h081C, 8'h00, "R6 read sysctl zero-extended");
        access(0, 1, 16'h081C, 8'hF0, "R6 write clears low bits");
        access(1, 0, 16'h081C, 8'h00, "R6 read cleared");

        // R7 map mode
        access(0, 1, 16'h0850, 8'h03, "R7 write map");
        access(1, 0, 16'h0850, 8'h00, "R7 read map");
        access(0, 1, 16'h0850, 8'hFE, "R7 clear map");
        access(1, 0, 16'h0850, 8'h00, "R7 read map cleared");

        // R8 cache invalidate port
        access(0, 1, 16'h0814, 8'hFF, "R8 write 0x0814");
        access(1, 0, 16'h0814, 8'h00, "R8 read 0x0814");

        // R9 undecoded ports
        access(0, 1, 16'h0808, 8'h01, "R9 setup lamp");
        access(1, 0, 16'h0801, 8'h00, "R9 read undecoded 0x0801");
        access(1, 0, 16'h0808, 8'h00, "R9 read write-only 0x0808");
        access(1, 0, 16'h0812, 8'h00, "R9 read write-only 0x0812");
        access(0, 1, 16'h0801, 8'hFF, "R9 write undecoded 0x0801");
        access(0, 1, 16'h080C, 8'h00, "R9 write read-only 0x080C");
        access(0, 1, 16'h0093, 8'h00, "R9 write 0x0093 keeps levels");
        access(1, 0, 16'hFFFF, 8'h00, "R9 read 0xFFFF");
        idle("R9 error clears");

        // R10 back-to-back reads
        access(1, 0, 16'h0803, 8'h00, "R10 read stream 1");
        access(1, 0, 16'h0802, 8'h00, "R10 read stream 2");
        idle("R10 rdata zero when idle");

        // R11 simultaneous strobes
        access(1, 1, 16'h081C, 8'h05, "R11 both strobes write sysctl");
        access(1, 1, 16'h0810, 8'h00, "R11 both strobes lock1");
        idle("R11 settle");
        access(1, 0, 16'h081C, 8'h00, "R11 readback");
        idle("R11 drain");

        // R1 mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        m_rst = 0; m_le = 0; m_led = 0; m_sys = 0; m_map = 0;
        @(negedge clk);
        check_reset("R1 reset mid-run");
        rst_n = 1'b1;
        idle("R1 levels after second reset");
        idle("R1 drain");
        repeat (3) @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule